// File: doc/BRIEF.md
# Delayed Read Completion Controller

This controller tracks a single delayed read held by a bus bridge between its initiator-facing side and its target-facing side. When an initiator first asks for the read, the controller tells it to retry and enters the read into the delayed queue. It then issues the read toward the target and keeps re-issuing it for as long as the target answers with retry.

Once the target gives a final answer (data, disconnect, target abort or master abort), the controller keeps the outcome. The next time the initiator comes back, it answers with the matching termination and frees the entry. A saturating attempt counter bounds the number of retried attempts. When that budget runs out, the entry is dropped and a system-error request is raised, provided error reporting is enabled and the non-delivery report is not masked.

All outputs are registered and valid one clock after the input strobe that caused them. Data transfer, bus signalling and transaction ordering are handled by other blocks.

Top module: `drc_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is low, `ini_resp_o` is 0 and no read is held.
- R2: A request from the initiator while no read is held produces `ini_resp_vld_o`=1 with code RETRY (0) on the next cycle. `tgt_issue_o` pulses one cycle after that, which starts the first attempt.
- R3: A request arriving while the read is being queued, or while an issued attempt has not yet been answered, is answered with RETRY (0).
- R4: A target answer of RETRY (`tgt_code_i`=1) while an attempt is outstanding pulses `tgt_issue_o` on the next cycle, as long as the budget is not yet used up. Each such answer adds one to the attempt count.
- R5: A normal completion (`tgt_code_i`=0) of a prefetchable read is delivered as DATA (1), or as DISCONNECT (2) when `ini_more_i` is high on the delivering request. A normal completion of a non-prefetchable read is always delivered as DISCONNECT (2). Prefetchability is taken from `ini_pref_i` on the request that opened the entry.
- R6: A target disconnect (`tgt_code_i`=2) is delivered as DISCONNECT (2) when `ini_more_i` is high on the delivering request, and otherwise as DATA (1).
- R7: A target abort (`tgt_code_i`=3) pulses `rx_tabort_o` on the cycle after the target answer. It is then delivered as TARGET_ABORT (3), together with a one-cycle `sig_tabort_o` pulse.
- R8: A master abort (`tgt_code_i`=4) is delivered as MASTER_ABORT (4) and frees the entry.
- R9: The RETRY_LIMIT-th target retry of one read issues no further attempt and drops the entry. It pulses `serr_o` exactly once, and only if `serr_en_i` is high and `nodeliv_mask_i` is low on that cycle.
- R10: After a final delivery or a dropped entry, the next initiator request is handled as a new read, as described in R2.
- R11: A target strobe while no attempt is outstanding, or one carrying a code from 5 to 7, has no effect on any output or on the later delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| serr_en_i | input | 1 | System-error reporting enable |
| nodeliv_mask_i | input | 1 | Masks the non-delivery system-error report |
| ini_req_i | input | 1 | Initiator request strobe for the read |
| ini_pref_i | input | 1 | Read is prefetchable (sampled on the opening request) |
| ini_more_i | input | 1 | Initiator wants more data than was fetched |
| tgt_done_i | input | 1 | Target answer strobe |
| tgt_code_i | input | 3 | Target answer: 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| tgt_issue_o | output | 1 | Pulse: issue an attempt toward the target |
| ini_resp_vld_o | output | 1 | Initiator response valid |
| ini_resp_o | output | 3 | 0 retry, 1 data, 2 disconnect, 3 target abort, 4 master abort |
| rx_tabort_o | output | 1 | Pulse: set received-target-abort status on the target side |
| sig_tabort_o | output | 1 | Pulse: set signaled-target-abort status on the initiator side |
| serr_o | output | 1 | Pulse: system-error request on an exhausted retry budget |

## Verification
A stuck or wrong state shows at the ports within one cycle of the next strobe. A request then gets a final code where RETRY was due, or RETRY where a final code was due. A target answer that should start a new attempt fails to pulse `tgt_issue_o`, or an ignored strobe pulses it. A stale stored outcome or prefetch flag shows up as a wrong delivered code when the initiator returns. A counter that is off by one moves the `serr_o` pulse and the last issued attempt by one retry, and this shows on the cycle after the last target answer. The bench model follows each of these cycle by cycle, so any difference is reported on the cycle where it first appears.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [2:0] {
    TC_NORMAL = 3'd0,
    TC_RETRY  = 3'd1,
    TC_DISC   = 3'd2,
    TC_TABORT = 3'd3,
    TC_MABORT = 3'd4
  } tgt_code_e;

  typedef enum logic [2:0] {
    IR_RETRY  = 3'd0,
    IR_DATA   = 3'd1,
    IR_DISC   = 3'd2,
    IR_TABORT = 3'd3,
    IR_MABORT = 3'd4
  } ini_resp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_WAIT  = 2'd2,
    ST_COMPL = 2'd3
  } drc_state_e;

  // Initiator-side termination for a stored target outcome
  function automatic ini_resp_e map_resp(tgt_code_e outc, logic pref, logic more);
    ini_resp_e r;
    case (outc)
      TC_NORMAL: r = (pref && !more) ? IR_DATA : IR_DISC;
      TC_DISC:   r = more ? IR_DISC : IR_DATA;
      TC_TABORT: r = IR_TABORT;
      TC_MABORT: r = IR_MABORT;
      default:   r = IR_RETRY;
    endcase
    return r;
  endfunction

  function automatic logic code_known(logic [2:0] c);
    return c <= 3'd4;
  endfunction

endpackage

// File: rtl/drc_retry_ctr.sv
module drc_retry_ctr #(
  parameter int unsigned LIMIT = 32'd16777216,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);

  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] c);
    return (c == LIM) ? c : c + 1'b1;
  endfunction

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = sat_inc(cnt_q);
  assign hit_o  = inc_i && (cnt_nx == LIM);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nx;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q < LIM) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/drc_resp_map.sv
module drc_resp_map
  import drc_pkg::*;
(
  input  tgt_code_e outc_i,
  input  logic      pref_i,
  input  logic      more_i,
  output ini_resp_e resp_o
);

  assign resp_o = map_resp(outc_i, pref_i, more_i);

endmodule

// File: rtl/drc_ctrl.sv
module drc_ctrl
  import drc_pkg::*;
#(
  parameter int unsigned RETRY_LIMIT = 32'd16777216
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serr_en_i,
  input  logic       nodeliv_mask_i,
  input  logic       ini_req_i,
  input  logic       ini_pref_i,
  input  logic       ini_more_i,
  input  logic       tgt_done_i,
  input  logic [2:0] tgt_code_i,
  output logic       tgt_issue_o,
  output logic       ini_resp_vld_o,
  output logic [2:0] ini_resp_o,
  output logic       rx_tabort_o,
  output logic       sig_tabort_o,
  output logic       serr_o
);

  localparam int unsigned CW = $clog2(RETRY_LIMIT + 1);

  drc_state_e st_q, st_d;
  tgt_code_e  outc_q;
  logic       pref_q;
  tgt_code_e  code_in;

  // Named internal events
  logic ev_new, ev_tgt_ans, ev_tgt_retry, ev_final, ev_exhaust, ev_deliver;
  logic [CW-1:0] att_cnt;
  ini_resp_e     mapped;

  assign code_in      = tgt_code_e'(tgt_code_i);
  assign ev_new       = (st_q == ST_IDLE) && ini_req_i;
  assign ev_tgt_ans   = (st_q == ST_WAIT) && tgt_done_i && code_known(tgt_code_i);
  assign ev_tgt_retry = ev_tgt_ans && (code_in == TC_RETRY);
  assign ev_final     = ev_tgt_ans && (code_in != TC_RETRY);
  assign ev_deliver   = (st_q == ST_COMPL) && ini_req_i;

  drc_retry_ctr #(.LIMIT(RETRY_LIMIT), .CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (st_q == ST_ENTER),
    .inc_i (ev_tgt_retry),
    .cnt_o (att_cnt),
    .hit_o (ev_exhaust)
  );

  drc_resp_map u_map (
    .outc_i (outc_q),
    .pref_i (pref_q),
    .more_i (ini_more_i),
    .resp_o (mapped)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (ev_new) st_d = ST_ENTER;
      ST_ENTER: st_d = ST_WAIT;
      ST_WAIT: begin
        if (ev_exhaust)    st_d = ST_IDLE;
        else if (ev_final) st_d = ST_COMPL;
      end
      ST_COMPL: if (ev_deliver) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      outc_q         <= TC_NORMAL;
      pref_q         <= 1'b0;
      tgt_issue_o    <= 1'b0;
      ini_resp_vld_o <= 1'b0;
      ini_resp_o     <= 3'd0;
      rx_tabort_o    <= 1'b0;
      sig_tabort_o   <= 1'b0;
      serr_o         <= 1'b0;
    end else begin
      st_q           <= st_d;
      if (ev_final) outc_q <= code_in;
      if (ev_new)   pref_q <= ini_pref_i;
      tgt_issue_o    <= (st_q == ST_ENTER) || (ev_tgt_retry && !ev_exhaust);
      ini_resp_vld_o <= ini_req_i;
      ini_resp_o     <= ev_deliver ? mapped : IR_RETRY;
      rx_tabort_o    <= ev_final && (code_in == TC_TABORT);
      sig_tabort_o   <= ev_deliver && (outc_q == TC_TABORT);
      serr_o         <= ev_exhaust && serr_en_i && !nodeliv_mask_i;
    end
  end

  AST_ISSUE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_issue_o |-> (st_q == ST_WAIT)); // R4

  AST_RETRY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_req_i && (st_q == ST_ENTER || st_q == ST_WAIT))
      |=> (ini_resp_vld_o && ini_resp_o == IR_RETRY)); // R3

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> ($past(serr_en_i) && !$past(nodeliv_mask_i) && st_q == ST_IDLE)); // R9

  AST_SERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> !tgt_issue_o); // R9

  AST_SIG_WITH_TABORT: assert property (@(posedge clk) disable iff (!rst_n)
    sig_tabort_o |-> (ini_resp_vld_o && ini_resp_o == IR_TABORT)); // R7

  AST_FINAL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_resp_vld_o && ini_resp_o != IR_RETRY) |-> (st_q == ST_IDLE)); // R10

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_tabort_o, sig_tabort_o, serr_o})); // R7

  AST_CNT_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) == ST_ENTER) |-> (att_cnt == '0)); // R4

endmodule

// File: tb/tb_drc_ctrl.sv
module tb_drc_ctrl;

  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serr_en_i = 1'b1, nodeliv_mask_i = 1'b0;
  logic ini_req_i = 1'b0, ini_pref_i = 1'b0, ini_more_i = 1'b0;
  logic tgt_done_i = 1'b0;
  logic [2:0] tgt_code_i = 3'd0;
  logic tgt_issue_o, ini_resp_vld_o, rx_tabort_o, sig_tabort_o, serr_o;
  logic [2:0] ini_resp_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  drc_ctrl #(.RETRY_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .serr_en_i(serr_en_i), .nodeliv_mask_i(nodeliv_mask_i),
    .ini_req_i(ini_req_i), .ini_pref_i(ini_pref_i), .ini_more_i(ini_more_i),
    .tgt_done_i(tgt_done_i), .tgt_code_i(tgt_code_i), .tgt_issue_o(tgt_issue_o),
    .ini_resp_vld_o(ini_resp_vld_o), .ini_resp_o(ini_resp_o), .rx_tabort_o(rx_tabort_o),
    .sig_tabort_o(sig_tabort_o), .serr_o(serr_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 free, 1 queuing, 2 outstanding, 3 answered
  int m_phase = 0, m_tries = 0, m_outc = 0;
  bit m_pref = 0;
  int e_iss = 0, e_rv = 0, e_rc = 0, e_rx = 0, e_sig = 0, e_serr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_tries = 0; m_outc = 0; m_pref = 0;
      e_iss = 0; e_rv = 0; e_rc = 0; e_rx = 0; e_sig = 0; e_serr = 0;
    end else begin
      e_iss = 0; e_rx = 0; e_sig = 0; e_serr = 0;
      e_rv = ini_req_i; e_rc = 0;
      if (m_phase == 0) begin
        if (ini_req_i) begin m_phase = 1; m_pref = ini_pref_i; end
      end else if (m_phase == 1) begin
        m_phase = 2; m_tries = 0; e_iss = 1;
      end else if (m_phase == 2) begin
        if (tgt_done_i && tgt_code_i == 1) begin
          m_tries++;
          if (m_tries >= LIM) begin
            m_phase = 0;
            e_serr = (serr_en_i && !nodeliv_mask_i) ? 1 : 0;
          end else e_iss = 1;
        end else if (tgt_done_i && tgt_code_i <= 4) begin
          m_outc = tgt_code_i; m_phase = 3;
          if (tgt_code_i == 3) e_rx = 1;
        end
      end else if (ini_req_i) begin
        if (m_outc == 0)      e_rc = m_pref ? (ini_more_i ? 2 : 1) : 2;
        else if (m_outc == 2) e_rc = ini_more_i ? 2 : 1;
        else                  e_rc = m_outc;
        if (m_outc == 3) e_sig = 1;
        m_phase = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk("R4 issue (model)", tgt_issue_o, e_iss);
      chk("R3 resp valid (model)", ini_resp_vld_o, e_rv);
      chk("R5 resp code (model)", ini_resp_o, e_rc);
      chk("R7 rx abort (model)", rx_tabort_o, e_rx);
      chk("R7 sig abort (model)", sig_tabort_o, e_sig);
      chk("R9 serr (model)", serr_o, e_serr);
    end
  end

  // Directed helpers: entered and left at a falling edge
  task automatic req(input bit more, input int exp, input string tag);
    ini_req_i = 1; ini_more_i = more;
    @(negedge clk);
    ini_req_i = 0; ini_more_i = 0;
    chk(tag, ini_resp_vld_o, 1);
    chk(tag, ini_resp_o, exp);
  endtask

  task automatic tgt(input int code);
    tgt_done_i = 1; tgt_code_i = 3'(code);
    @(negedge clk);
    tgt_done_i = 0; tgt_code_i = 0;
  endtask

  task automatic open_read(input bit pref, input string tag);
    ini_pref_i = pref;
    req(0, 0, tag);
    ini_pref_i = 0;
    @(negedge clk);
    chk({tag, " first issue"}, tgt_issue_o, 1);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 issue in reset", tgt_issue_o, 0);
    chk("R1 serr in reset", serr_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 resp after reset", ini_resp_vld_o, 0);
    chk("R1 code after reset", ini_resp_o, 0);

    // R11: stray target strobe with nothing outstanding
    tgt(3);
    chk("R11 stray abort rx", rx_tabort_o, 0);
    chk("R11 stray abort issue", tgt_issue_o, 0);

    // R2, R3, R5 prefetchable normal
    open_read(1, "R2");
    req(1, 0, "R3 pending retry");
    tgt(0);
    tgt(3); // R11: ignored once answered
    chk("R11 answered stray rx", rx_tabort_o, 0);
    req(0, 1, "R5 pref data");
    open_read(1, "R10 new read");
    tgt(0);
    req(1, 2, "R5 pref more disconnect");

    // R5 non-prefetchable
    open_read(0, "R2");
    tgt(0);
    req(0, 2, "R5 nonpref disconnect");

    // R6 disconnect
    open_read(1, "R2");
    tgt(2);
    req(0, 1, "R6 disc no more");
    open_read(0, "R2");
    tgt(2);
    req(1, 2, "R6 disc more");

    // R7 target abort
    open_read(1, "R2");
    tgt(3);
    chk("R7 rx pulse", rx_tabort_o, 1);
    req(0, 3, "R7 abort delivered");
    chk("R7 sig pulse", sig_tabort_o, 1);

    // R8 master abort, plus unknown code ignored (R11)
    open_read(0, "R2");
    tgt(6);
    chk("R11 unknown code issue", tgt_issue_o, 0);
    tgt(4);
    req(0, 4, "R8 master abort");
    open_read(0, "R10 after master abort");

    // R4 retries then completion
    for (int i = 0; i < 3; i++) begin
      tgt(1);
      chk("R4 reissue", tgt_issue_o, 1);
    end
    req(0, 0, "R3 retry while retrying");
    tgt(0);
    req(0, 2, "R5 after retries");

    // R9 exhaustion: enabled, masked, disabled
    for (int k = 0; k < 3; k++) begin
      serr_en_i = (k != 2); nodeliv_mask_i = (k == 1);
      open_read(1, "R2");
      for (int i = 0; i < LIM - 1; i++) begin
        tgt(1);
        chk("R4 reissue under budget", tgt_issue_o, 1);
      end
      tgt(1);
      chk("R9 no issue at limit", tgt_issue_o, 0);
      chk("R9 serr gating", serr_o, (k == 0) ? 1 : 0);
      @(negedge clk);
      chk("R9 serr once", serr_o, 0);
      req(0, 0, "R10 new after drop");
      @(negedge clk);
      chk("R10 new issue after drop", tgt_issue_o, 1);
      tgt(4);
      req(0, 4, "R8 cleanup");
    end
    serr_en_i = 1; nodeliv_mask_i = 0;

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule